// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recently used page translations for a 32-bit virtual address space built from 8 KB pages. A probe presents a virtual address with its access type (load or store). The block compares the virtual page number against every stored entry at once. On a hit it returns the physical address, the frame number followed by the untouched page offset, in the same cycle. It also returns the entry's reference and dirty status as they stood before the access.

Each entry carries a valid flag, a write permission flag, a reference flag and a dirty flag. A store through an entry without write permission is reported as a protection fault, and it leaves the entry's flags alone. A reference that completes marks the entry referenced, and a store that completes also marks it dirty. A probe that finds no entry latches the missing page number and the access type. The block presents them on its miss outputs until an external walker answers with a refill or the whole buffer is flushed.

A refill first reuses an entry that already holds the same page. Failing that, it takes a free entry, and only then evicts. The eviction choice never falls on the entry most recently hit.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual page number is `req_va[31:13]` and the offset is `req_va[12:0]`. On a hit, `resp_pa` equals `{frame, req_va[12:0]}` in the same cycle as the probe.
- R2: There are 48 entries (parameter `ENTRIES`), and any page may occupy any entry. 48 distinct pages refilled after a flush all hit afterwards.
- R3: An entry whose valid flag is clear never produces `resp_hit`. After reset no probe hits and `miss_pending` is 0.
- R4: A store (`req_store`=1) that hits an entry with write permission clear asserts `resp_fault` along with `resp_hit`. It sets neither the reference flag nor the dirty flag of that entry.
- R5: A load, or a permitted store, that hits sets the entry's reference flag from the next cycle on. A later hit shows this flag on `resp_ref`.
- R6: A permitted store that hits sets the entry's dirty flag from the next cycle on. A later hit shows this flag on `resp_dirty`.
- R7: A probe that misses while no miss is pending sets `miss_pending` from the next cycle. It also captures `miss_vpn` and `miss_store`, and all three hold unchanged until a refill or flush. Further misses in that interval do not replace them.
- R8: A refill writes the entry with valid set, write permission from `fill_wen`, reference and dirty cleared, and the given frame. It also clears `miss_pending`. A refill whose page is already present overwrites that entry, so at most one entry ever matches a page.
- R9: When no entry is free, the refill victim is never the entry most recently hit. This includes an entry hit in the same cycle as the refill.
- R10: `flush` clears every valid flag and `miss_pending` in one cycle. A refill presented in the same cycle is discarded.
- R11: A probe in the same cycle as a refill sees the contents from before the refill. The refill is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries and cancel a pending miss |
| req_valid | input | 1 | Probe present this cycle |
| req_store | input | 1 | Probe is a store (1) or a load (0) |
| req_va | input | 32 | Probe virtual address |
| resp_hit | output | 1 | A valid entry matches the probed page |
| resp_fault | output | 1 | Store hit on an entry without write permission |
| resp_pa | output | 32 | Physical address, meaningful with resp_hit |
| resp_ref | output | 1 | Reference flag of the hit entry before this access |
| resp_dirty | output | 1 | Dirty flag of the hit entry before this access |
| miss_pending | output | 1 | A miss awaits a refill |
| miss_vpn | output | 19 | Page number of the pending miss |
| miss_store | output | 1 | Access type of the pending miss |
| fill_valid | input | 1 | Refill present this cycle |
| fill_vpn | input | 19 | Page number being installed |
| fill_pfn | input | 19 | Frame number being installed |
| fill_wen | input | 1 | Write permission of the new entry |

## Verification
The risky overlap is a probe hit that updates an entry's flags, or picks the protected entry, in the same cycle that a refill writes the buffer. A refill or flush arriving while a miss is being captured is a second such case. The random phase draws probes, refills and occasional flushes on independent dice over a page pool small enough that nothing is evicted. A reference model then predicts every response, flag and miss output exactly. Directed sequences cover the remaining cases: a refill of the very page being probed, a flush carrying a refill, and a full buffer refilled 47 times while one page is probed in the same cycles and must survive every eviction.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W  = 32;
    parameter int OFF_W = 13;
    parameter int VPN_W = VA_W - OFF_W;
    parameter int PFN_W = 19;
    parameter int PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        logic             valid;
        logic             wen;
        logic             refd;
        logic             dirty;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valids,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            match,
    output logic                          found,
    output logic [IDX_W-1:0]              idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valids[g] && (tags[g] == key);
    end

    always_comb begin
        found = |match;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valids,
    input  logic [IDX_W-1:0]   protect,
    input  logic [IDX_W-1:0]   ptr,
    output logic               free_found,
    output logic [IDX_W-1:0]   free_idx,
    output logic [IDX_W-1:0]   rr_idx,
    output logic [IDX_W-1:0]   rr_next
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_comb begin
        free_found = ~&valids;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valids[i]) free_idx = IDX_W'(i);
        end
        if (ptr == protect) rr_idx = (ptr == LAST) ? '0 : ptr + 1'b1;
        else                rr_idx = ptr;
        rr_next = (rr_idx == LAST) ? '0 : rr_idx + 1'b1;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic [VA_W-1:0]  req_va,
    output logic             resp_hit,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_pa,
    output logic             resp_ref,
    output logic             resp_dirty,
    output logic             miss_pending,
    output logic [VPN_W-1:0] miss_vpn,
    output logic             miss_store,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_wen
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]         last;
        logic [IDX_W-1:0]         ptr;
        logic                     pend;
        logic [VPN_W-1:0]         mvpn;
        logic                     mstore;
    } state_t;

    state_t s_q, s_d;

    logic [ENTRIES-1:0][VPN_W-1:0] tags;
    logic [ENTRIES-1:0]            valids;
    logic [ENTRIES-1:0]            hit_vec, fill_vec;
    logic                          any_hit, fill_dup;
    logic [IDX_W-1:0]              hit_idx, dup_idx;
    logic                          free_found;
    logic [IDX_W-1:0]              free_idx, rr_idx, rr_next, protect;
    logic                          complete;
    logic [IDX_W-1:0]              wr_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_tag
        assign tags[g]   = s_q.ent[g].vpn;
        assign valids[g] = s_q.ent[g].valid;
    end

    tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_probe_cam (
        .tags(tags), .valids(valids), .key(req_va[VA_W-1:OFF_W]),
        .match(hit_vec), .found(any_hit), .idx(hit_idx)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_fill_cam (
        .tags(tags), .valids(valids), .key(fill_vpn),
        .match(fill_vec), .found(fill_dup), .idx(dup_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
        .valids(valids), .protect(protect), .ptr(s_q.ptr),
        .free_found(free_found), .free_idx(free_idx),
        .rr_idx(rr_idx), .rr_next(rr_next)
    );

    // Responses come straight from the registered entries.
    always_comb begin
        resp_hit     = req_valid && any_hit;
        resp_fault   = resp_hit && req_store && !s_q.ent[hit_idx].wen;
        resp_pa      = {s_q.ent[hit_idx].pfn, req_va[OFF_W-1:0]};
        resp_ref     = s_q.ent[hit_idx].refd;
        resp_dirty   = s_q.ent[hit_idx].dirty;
        miss_pending = s_q.pend;
        miss_vpn     = s_q.mvpn;
        miss_store   = s_q.mstore;
        complete     = resp_hit && !resp_fault;
        protect      = complete ? hit_idx : s_q.last;
    end

    always_comb begin
        s_d    = s_q;
        wr_idx = fill_dup ? dup_idx : (free_found ? free_idx : rr_idx);
        if (complete) begin
            s_d.ent[hit_idx].refd = 1'b1;
            if (req_store) s_d.ent[hit_idx].dirty = 1'b1;
            s_d.last = hit_idx;
        end
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) s_d.ent[i].valid = 1'b0;
            s_d.pend = 1'b0;
        end else if (fill_valid) begin
            if (!fill_dup && !free_found) s_d.ptr = rr_next;
            s_d.ent[wr_idx] = '{valid: 1'b1, wen: fill_wen, refd: 1'b0,
                                dirty: 1'b0, vpn: fill_vpn, pfn: fill_pfn};
            s_d.pend = 1'b0;
        end else if (req_valid && !any_hit && !s_q.pend) begin
            s_d.pend   = 1'b1;
            s_d.mvpn   = req_va[VA_W-1:OFF_W];
            s_d.mstore = req_store;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               req_valid,
    input logic               req_store,
    input logic [VA_W-1:0]    req_va,
    input logic               resp_hit,
    input logic               resp_fault,
    input logic [PA_W-1:0]    resp_pa,
    input logic               miss_pending,
    input logic [VPN_W-1:0]   miss_vpn,
    input logic               fill_valid,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] fill_vec
);
    p_pa_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (resp_pa[OFF_W-1:0] == req_va[OFF_W-1:0]));

    p_fault_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_hit && req_store));

    p_miss_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_pending && !fill_valid && !flush) |=> (miss_pending && $stable(miss_vpn)));

    p_miss_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss_pending) |-> $past(req_valid && !resp_hit && !flush && !fill_valid));

    p_one_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_one_fill_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_vec));

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!resp_hit && !miss_pending));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES)) i_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_store(req_store), .req_va(req_va), .resp_hit(resp_hit),
    .resp_fault(resp_fault), .resp_pa(resp_pa), .miss_pending(miss_pending),
    .miss_vpn(miss_vpn), .fill_valid(fill_valid), .hit_vec(hit_vec),
    .fill_vec(fill_vec)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0, req_valid = 1'b0, req_store = 1'b0;
    logic [31:0] req_va = '0;
    logic        resp_hit, resp_fault, resp_ref, resp_dirty;
    logic [31:0] resp_pa;
    logic        miss_pending, miss_store;
    logic [18:0] miss_vpn;
    logic        fill_valid = 1'b0, fill_wen = 1'b0;
    logic [18:0] fill_vpn = '0, fill_pfn = '0;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
        .req_store(req_store), .req_va(req_va), .resp_hit(resp_hit),
        .resp_fault(resp_fault), .resp_pa(resp_pa), .resp_ref(resp_ref),
        .resp_dirty(resp_dirty), .miss_pending(miss_pending),
        .miss_vpn(miss_vpn), .miss_store(miss_store), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_wen(fill_wen)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    bit          m_v [int];
    bit          m_w [int];
    bit          m_r [int];
    bit          m_d [int];
    logic [18:0] m_pfn [int];
    bit          m_pend = 1'b0, m_mst = 1'b0;
    logic [18:0] m_mvpn = '0;

    logic        s_hit;
    logic [31:0] s_pa;

    function automatic logic [18:0] pool(int i);
        return 19'(32'h100 + i * 37);
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit rv, bit st, logic [31:0] va, bit fv,
                        logic [18:0] fvpn, logic [18:0] fpfn, bit fw, bit fl, bit mchk);
        int k;
        bit eh, ef;
        @(negedge clk);
        req_valid = rv; req_store = st; req_va = va;
        fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; fill_wen = fw; flush = fl;
        #1;
        s_hit = resp_hit;
        s_pa  = resp_pa;
        k  = int'(va[31:13]);
        eh = rv && m_v.exists(k);
        ef = eh && st && !m_w[k];
        if (mchk) begin
            check(tag, "hit", 64'(resp_hit), 64'(eh));
            check(tag, "fault", 64'(resp_fault), 64'(ef));
            if (eh) begin
                check(tag, "pa", 64'(resp_pa), 64'({m_pfn[k], va[12:0]}));
                check(tag, "ref", 64'(resp_ref), 64'(m_r[k]));
                check(tag, "dirty", 64'(resp_dirty), 64'(m_d[k]));
            end
            check(tag, "pend", 64'(miss_pending), 64'(m_pend));
            if (m_pend) begin
                check(tag, "mvpn", 64'(miss_vpn), 64'(m_mvpn));
                check(tag, "mstore", 64'(miss_store), 64'(m_mst));
            end
        end
        @(posedge clk);
        if (eh && !ef) begin
            m_r[k] = 1'b1;
            if (st) m_d[k] = 1'b1;
        end
        if (fl) begin
            m_v.delete();
            m_pend = 1'b0;
        end else if (fv) begin
            m_v[int'(fvpn)] = 1'b1; m_w[int'(fvpn)] = fw;
            m_r[int'(fvpn)] = 1'b0; m_d[int'(fvpn)] = 1'b0;
            m_pfn[int'(fvpn)] = fpfn;
            m_pend = 1'b0;
        end else if (rv && !eh && !m_pend) begin
            m_pend = 1'b1; m_mvpn = va[31:13]; m_mst = st;
        end
    endtask

    task automatic probe(string tag, bit st, logic [31:0] va);
        step(tag, 1'b1, st, va, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic fill(string tag, logic [18:0] vpn, logic [18:0] pfn, bit w);
        step(tag, 1'b0, 1'b0, '0, 1'b1, vpn, pfn, w, 1'b0, 1'b1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: empty after reset
        probe("R3", 1'b0, {pool(0), 13'h0});
        check("R3", "hit after reset", 64'(s_hit), 64'd0);
        // the miss above is pending; refill clears it
        fill("R8", pool(0), 19'h5A5A5, 1'b1);
        // R1: both offset extremes and a middle one
        probe("R1", 1'b0, {pool(0), 13'h1ABC});
        probe("R1", 1'b0, {pool(0), 13'h0000});
        probe("R1", 1'b0, {pool(0), 13'h1FFF});
        check("R1", "pa", 64'(s_pa), 64'({19'h5A5A5, 13'h1FFF}));
        // R5 / R6: flags appear on later hits
        probe("R6", 1'b1, {pool(0), 13'h10});
        probe("R6", 1'b0, {pool(0), 13'h10});
        // R4: store to a read-only page faults, flags untouched
        fill("R4", pool(1), 19'h00333, 1'b0);
        probe("R4", 1'b1, {pool(1), 13'h4});
        probe("R4", 1'b0, {pool(1), 13'h4});
        probe("R5", 1'b0, {pool(1), 13'h4});
        // R7: miss capture and hold against later misses
        probe("R7", 1'b1, {pool(2), 13'h7});
        probe("R7", 1'b0, {pool(3), 13'h7});
        probe("R7", 1'b0, {pool(0), 13'h7});
        check("R7", "held vpn", 64'(miss_vpn), 64'(pool(2)));
        fill("R7", pool(2), 19'h00444, 1'b1);
        probe("R7", 1'b0, {pool(2), 13'h7});
        // R8: refill of a present page overwrites, flags cleared
        fill("R8", pool(0), 19'h01111, 1'b0);
        probe("R8", 1'b1, {pool(0), 13'h20});
        // R11: probe and refill of the same page together
        step("R11", 1'b1, 1'b0, {pool(1), 13'h30}, 1'b1, pool(1), 19'h02222, 1'b1, 1'b0, 1'b1);
        check("R11", "old pa", 64'(s_pa), 64'({19'h00333, 13'h30}));
        probe("R11", 1'b0, {pool(1), 13'h30});
        check("R11", "new pa", 64'(s_pa), 64'({19'h02222, 13'h30}));
        // R10: flush with a refill in the same cycle
        probe("R10", 1'b0, {pool(9), 13'h0});
        step("R10", 1'b0, 1'b0, '0, 1'b1, pool(4), 19'h1, 1'b1, 1'b1, 1'b1);
        probe("R10", 1'b0, {pool(4), 13'h0});
        check("R10", "dropped fill", 64'(s_hit), 64'd0);
        probe("R10", 1'b0, {pool(1), 13'h0});

        // R2 / R9: fill every entry, then evict while one page stays hot
        step("R10", 1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 48; i++)
            step("R2", 1'b0, 1'b0, '0, 1'b1, 19'h40000 + 19'(i), 19'(i), 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 48; i++) begin
            step("R2", 1'b1, 1'b0, {19'h40000 + 19'(i), 13'h5}, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
            check("R2", "hit", 64'(s_hit), 64'd1);
            check("R2", "pa", 64'(s_pa), 64'({19'(i), 13'h5}));
        end
        step("R9", 1'b1, 1'b0, {19'h40005, 13'h0}, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        for (int j = 0; j < 47; j++) begin
            step("R9", 1'b1, 1'b0, {19'h40005, 13'h0}, 1'b1, 19'h50000 + 19'(j),
                 19'(100 + j), 1'b1, 1'b0, 1'b0);
            check("R9", "hot page kept", 64'(s_hit), 64'd1);
        end
        step("R9", 1'b1, 1'b0, {19'h40005, 13'h1}, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        check("R9", "hot page final", 64'(s_pa), 64'({19'd5, 13'h1}));
        step("R8", 1'b1, 1'b0, {19'h5002E, 13'h1}, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        check("R8", "last fill", 64'(s_pa), 64'({19'd146, 13'h1}));
        step("R10", 1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b1, 1'b1);

        // Random mix over a pool that never exceeds capacity
        for (int n = 0; n < 3000; n++) begin
            bit rv, st, fv, fw, fl;
            logic [31:0] va;
            rv = ($urandom % 4) != 0;
            st = $urandom % 2;
            va = {pool(int'($urandom % 32)), 13'($urandom)};
            fv = ($urandom % 100) < 15;
            fw = $urandom % 2;
            fl = ($urandom % 100) < 2;
            step("R1/R4/R5/R6/R7/R8/R10/R11", rv, st, va, fv, pool(int'($urandom % 32)),
                 19'($urandom), fw, fl, 1'b1);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule